// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. It accepts one multiply-accumulate operation per clock. Each 16-bit operand is widened to 17 bits as either a signed or an unsigned value. The two widened operands are multiplied. In fractional format the product is doubled. The product is then added to, subtracted from, or loaded into one of two 40-bit accumulators. The 40-bit width leaves eight guard bits above a 32-bit result. The sum can then be rounded and clamped to the 32-bit signed range. The new accumulator value, a zero flag and an overflow flag are all registered on the same clock edge.

The X operand always comes from a data-bus input. The Y operand comes either from a second data-bus input or from an internal T register, which a separate write strobe loads. The source accumulator and the destination accumulator are selected independently, so a single operation can read A and write B. Both accumulators are visible at the ports at all times.

Operations enter on a valid/ready handshake. `in_ready` is low during reset and high at all other times, so back-pressure exists only while the block is in reset. An operation is accepted on every rising edge where `in_valid` and `in_ready` are both high. Its result appears on the accumulator and flag outputs after that edge, and the next operation can be accepted on the following edge. When no operation is accepted, the accumulators and the flags hold their values.

Top module: `fxp_mac_unit`

## Requirements
- R1: During reset and on the first cycle after it, both accumulators are zero, both flags are low and `in_ready` is low until reset is released.
- R2: `x_signed`/`y_signed` high extend the operand with its bit 15; low extend it with a zero bit, so 0xFFFF means 65535.
- R3: `mac_op` encoding is 00 add (result = source + product), 01 subtract (result = source − product), and 10 or 11 load (result = product). `src_sel` picks the source and `dst_sel` picks the destination (0 = A, 1 = B). The accumulator that is not the destination is unchanged.
- R4: With `frac_en` high, the product is shifted left by one bit before it is accumulated.
- R5: With `frac_en` high and both operands signed 0x8000, the product becomes 0x007FFFFFFF instead of 2^31.
- R6: With `rnd_en` high, 0x8000 is added to the 40-bit result and bits 15:0 are then cleared. Rounding happens before the saturation check.
- R7: `ovf_flag` is set when the rounded result lies outside the signed 32-bit range, whether or not saturation is enabled. With `sat_en` high, such a result becomes 0x007FFFFFFF if positive and 0xFF80000000 if negative.
- R8: `zero_flag` is set when the value written to the destination accumulator is zero.
- R9: A high `t_wr` loads `t_data` into the T register on that edge, whatever the value of `in_valid`. With `y_from_t` high, the Y operand is the T register instead of `y_data`.
- R10: The result of an accepted operation appears on the edge that accepts it, and back-to-back operations are accepted. With `in_valid` low, the accumulators and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | An operation can be accepted (low in reset) |
| x_data | input | 16 | X operand from the data bus |
| y_data | input | 16 | Y operand from the data bus |
| t_wr | input | 1 | Load the T register |
| t_data | input | 16 | Value for the T register |
| x_signed | input | 1 | Sign-extend X |
| y_signed | input | 1 | Sign-extend Y |
| y_from_t | input | 1 | Take Y from the T register |
| frac_en | input | 1 | Fractional product doubling |
| mac_op | input | 2 | 00 add, 01 subtract, 1x load |
| src_sel | input | 1 | Source accumulator (0 A, 1 B) |
| dst_sel | input | 1 | Destination accumulator (0 A, 1 B) |
| rnd_en | input | 1 | Round the result |
| sat_en | input | 1 | Saturate the result to 32 signed bits |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| zero_flag | output | 1 | Last written result was zero |
| ovf_flag | output | 1 | Last result exceeded 32 signed bits |

## Verification
The bench multiplies 0xFFFF by itself as unsigned, as signed and with mixed signs. A sign-control error shows up there as a product of 1 where 0xFFFE0001 is expected, or the reverse. It drives 0x8000 × 0x8000 in fractional mode, where a missing special case leaves 0x0080000000 instead of 0x007FFFFFFF. It repeats the same operands non-fractional and unsigned to check that the special case does not trigger there. It rounds values just below and at the half point, so a wrong rounding constant or a missing low-bit clear leaves stray low bits. It pushes results past both ends of the 32-bit range with and without saturation, where a clamp or flag bug gives a wrapped value or a missing overflow. Cross-accumulator operations, T-register sourcing and idle cycles with noisy controls expose a wrong destination, a wrong operand source, or an update that should not have happened.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned ACC_W  = 40;
  localparam int unsigned RES_W  = 32;
  localparam int unsigned RND_LO = 16;

  typedef enum logic [1:0] {
    MAC_ADD  = 2'b00,
    MAC_SUB  = 2'b01,
    MAC_LOAD = 2'b10,
    MAC_LDX  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_sign_ext.sv
module mac_sign_ext #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] din,
  input  logic         is_signed,
  output logic [W:0]   dout
);
  assign dout = {is_signed & din[W-1], din};
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned W     = 16,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned RES_W = 32
) (
  input  logic [W:0]       a_ext,
  input  logic [W:0]       b_ext,
  input  logic             frac,
  output logic [ACC_W-1:0] prod
);
  localparam int unsigned EXT_W  = W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;
  localparam logic [EXT_W-1:0] NEG_MIN = {2'b11, {(W-1){1'b0}}};
  localparam logic [ACC_W-1:0] POS_MAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};

  logic signed [PROD_W-1:0] raw;
  logic        [PROD_W:0]   shifted;
  logic                     corner;

  assign raw     = $signed(a_ext) * $signed(b_ext);
  assign shifted = frac ? {raw, 1'b0} : {raw[PROD_W-1], raw};
  // both operands are the most negative signed value: doubled square does not fit
  assign corner  = frac && (a_ext == NEG_MIN) && (b_ext == NEG_MIN);

  always_comb begin
    if (corner) prod = POS_MAX;
    else        prod = {{(ACC_W-PROD_W-1){shifted[PROD_W]}}, shifted};
  end
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub
  import fxp_mac_pkg::*;
#(
  parameter int unsigned ACC_W = 40
) (
  input  logic [ACC_W-1:0] src,
  input  logic [ACC_W-1:0] prod,
  input  logic [1:0]       op,
  output logic [ACC_W-1:0] sum
);
  always_comb begin
    unique case (mac_op_e'(op))
      MAC_ADD: sum = src + prod;
      MAC_SUB: sum = src - prod;
      default: sum = prod;
    endcase
  end
endmodule

// File: rtl/mac_post.sv
module mac_post #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned RES_W  = 32,
  parameter int unsigned RND_LO = 16
) (
  input  logic [ACC_W-1:0] din,
  input  logic             rnd_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] dout,
  output logic             ovf,
  output logic             zero
);
  localparam logic [ACC_W-1:0] HALF    = {{(ACC_W-RND_LO){1'b0}}, 1'b1, {(RND_LO-1){1'b0}}};
  localparam logic [ACC_W-1:0] KEEP    = {{(ACC_W-RND_LO){1'b1}}, {RND_LO{1'b0}}};
  localparam logic [ACC_W-1:0] POS_MAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

  logic [ACC_W-1:0]       rounded;
  logic [ACC_W-RES_W:0]   top_bits;

  assign rounded  = rnd_en ? ((din + HALF) & KEEP) : din;
  assign top_bits = rounded[ACC_W-1:RES_W-1];
  assign ovf      = !((&top_bits) || !(|top_bits));

  always_comb begin
    if (sat_en && ovf) dout = rounded[ACC_W-1] ? NEG_MAX : POS_MAX;
    else               dout = rounded;
  end

  assign zero = (dout == '0);
endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit
  import fxp_mac_pkg::*;
#(
  parameter int unsigned W      = OP_W,
  parameter int unsigned AW     = ACC_W,
  parameter int unsigned RW     = RES_W,
  parameter int unsigned RLO    = RND_LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  x_data,
  input  logic [W-1:0]  y_data,
  input  logic          t_wr,
  input  logic [W-1:0]  t_data,
  input  logic          x_signed,
  input  logic          y_signed,
  input  logic          y_from_t,
  input  logic          frac_en,
  input  logic [1:0]    mac_op,
  input  logic          src_sel,
  input  logic          dst_sel,
  input  logic          rnd_en,
  input  logic          sat_en,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b,
  output logic          zero_flag,
  output logic          ovf_flag
);
  localparam int unsigned N_OPS = 2;

  logic              rdy_q;
  logic [W-1:0]      t_q;
  logic [AW-1:0]     acc_a_q, acc_b_q;
  logic              zero_q, ovf_q;
  logic              fire;

  logic [N_OPS-1:0][W-1:0] op_raw;
  logic [N_OPS-1:0]        op_sgn;
  logic [N_OPS-1:0][W:0]   op_ext;

  logic [AW-1:0] prod, src_val, sum, result;
  logic          res_ovf, res_zero;

  assign fire      = in_valid && rdy_q;
  assign in_ready  = rdy_q;
  assign op_raw[0] = x_data;
  assign op_raw[1] = y_from_t ? t_q : y_data;
  assign op_sgn    = {y_signed, x_signed};

  for (genvar g = 0; g < N_OPS; g++) begin : g_ext
    mac_sign_ext #(.W(W)) u_ext (
      .din      (op_raw[g]),
      .is_signed(op_sgn[g]),
      .dout     (op_ext[g])
    );
  end

  mac_mult #(.W(W), .ACC_W(AW), .RES_W(RW)) u_mult (
    .a_ext(op_ext[0]),
    .b_ext(op_ext[1]),
    .frac (frac_en),
    .prod (prod)
  );

  assign src_val = src_sel ? acc_b_q : acc_a_q;

  mac_addsub #(.ACC_W(AW)) u_addsub (
    .src (src_val),
    .prod(prod),
    .op  (mac_op),
    .sum (sum)
  );

  mac_post #(.ACC_W(AW), .RES_W(RW), .RND_LO(RLO)) u_post (
    .din   (sum),
    .rnd_en(rnd_en),
    .sat_en(sat_en),
    .dout  (result),
    .ovf   (res_ovf),
    .zero  (res_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      t_q   <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (t_wr) t_q <= t_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a_q <= '0;
      acc_b_q <= '0;
      zero_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (fire) begin
      if (dst_sel) acc_b_q <= result;
      else         acc_a_q <= result;
      zero_q <= res_zero;
      ovf_q  <= res_ovf;
    end
  end

  assign acc_a     = acc_a_q;
  assign acc_b     = acc_b_q;
  assign zero_flag = zero_q;
  assign ovf_flag  = ovf_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(acc_a_q) && $stable(acc_b_q) && $stable(zero_q) && $stable(ovf_q)));

  // R3
  other_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst_sel) |=> $stable(acc_a_q));

  // R7
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sat_en && !dst_sel) |=> ((&acc_a_q[AW-1:RW-1]) || !(|acc_a_q[AW-1:RW-1])));

  // R6
  round_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rnd_en && !sat_en && dst_sel) |=> (acc_b_q[RLO-1:0] == '0));

  // R8
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dst_sel) |=> (zero_q == (acc_a_q == '0)));

  // R8
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst_sel) |=> (zero_q == (acc_b_q == '0)));
endmodule

// File: tb/test_fxp_mac_unit.sv
module test_fxp_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] x_data = '0, y_data = '0, t_data = '0;
  logic        t_wr = 1'b0, x_signed = 1'b0, y_signed = 1'b0, y_from_t = 1'b0;
  logic        frac_en = 1'b0, src_sel = 1'b0, dst_sel = 1'b0, rnd_en = 1'b0, sat_en = 1'b0;
  logic [1:0]  mac_op = 2'b00;
  logic [39:0] acc_a, acc_b;
  logic        zero_flag, ovf_flag;

  always #10 clk = ~clk;

  fxp_mac_unit i_fxp_mac_unit (.*);

  typedef struct {
    string       req;
    logic [39:0] a, b;
    logic        z, o;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0, n_fail = 0;
  logic [39:0] m_a = '0, m_b = '0;
  logic [15:0] m_t = '0;
  logic        m_z = 1'b0, m_o = 1'b0;
  bit          done = 0;

  task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] x, y, input logic xs, ys, fr,
                                input logic [1:0] op, input logic [39:0] src,
                                input logic rnd, sat,
                                output logic [39:0] res, output logic ovf);
    longint xv, yv, p, s, r;
    logic [39:0] w;
    xv = xs ? longint'($signed(x)) : longint'(x);
    yv = ys ? longint'($signed(y)) : longint'(y);
    p  = xv * yv;
    if (fr) p = p * 2;
    if (fr && xs && ys && x == 16'h8000 && y == 16'h8000) p = 64'h7FFFFFFF;
    s = longint'($signed(src));
    if (op == 2'b00)      r = s + p;
    else if (op == 2'b01) r = s - p;
    else                  r = p;
    w = 40'(r);
    if (rnd) begin
      w = w + 40'h8000;
      w[15:0] = '0;
    end
    ovf = !(w[39:31] == 9'h000 || w[39:31] == 9'h1FF);
    if (sat && ovf) w = w[39] ? 40'hFF80000000 : 40'h007FFFFFFF;
    res = w;
  endfunction

  task automatic drive(input string req, input logic [15:0] x, y, input logic xs, ys, fr,
                       input logic [1:0] op, input logic src, dst, rnd, sat, yt);
    logic [39:0] res;
    logic        ovf;
    exp_t        e;
    model(x, yt ? m_t : y, xs, ys, fr, op, src ? m_b : m_a, rnd, sat, res, ovf);
    if (dst) m_b = res; else m_a = res;
    m_z = (res == '0);
    m_o = ovf;
    e.req = req; e.a = m_a; e.b = m_b; e.z = m_z; e.o = m_o;
    sb.push_back(e);
    x_data = x; y_data = y; x_signed = xs; y_signed = ys; frac_en = fr;
    mac_op = op; src_sel = src; dst_sel = dst; rnd_en = rnd; sat_en = sat; y_from_t = yt;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_t(input logic [15:0] d);
    t_wr = 1'b1; t_data = d;
    @(negedge clk);
    t_wr = 1'b0;
    m_t = d;
  endtask

  // monitor: pops one expected item per accepted operation
  initial begin
    bit seen;
    exp_t e;
    forever begin
      @(posedge clk);
      seen = in_valid && in_ready;
      @(negedge clk);
      if (seen) begin
        if (sb.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R10 unexpected result: actual %h expected none", acc_a);
        end else begin
          e = sb.pop_front();
          chk(e.req, "acc_a", acc_a, e.a);
          chk(e.req, "acc_b", acc_b, e.b);
          chk(e.req, "zero_flag", {39'b0, zero_flag}, {39'b0, e.z});
          chk(e.req, "ovf_flag", {39'b0, ovf_flag}, {39'b0, e.o});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "in_ready in reset", {39'b0, in_ready}, 40'd0);
    chk("R1", "acc_a in reset", acc_a, 40'd0);
    chk("R1", "acc_b in reset", acc_b, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", {39'b0, in_ready}, 40'd1);
    chk("R1", "flags after reset", {38'b0, zero_flag, ovf_flag}, 40'd0);

    // R3: modes and independent source/destination
    drive("R3", 16'd3, 16'd5, 1, 1, 0, 2'b10, 0, 0, 0, 0, 0);
    drive("R3", 16'd2, 16'd7, 1, 1, 0, 2'b00, 0, 0, 0, 0, 0);
    drive("R3", 16'd1, 16'd9, 1, 1, 0, 2'b01, 0, 1, 0, 0, 0);
    drive("R3", 16'd4, 16'd4, 1, 1, 0, 2'b11, 1, 0, 0, 0, 0);
    // R2: sign control
    drive("R2", 16'hFFFF, 16'hFFFF, 0, 0, 0, 2'b10, 0, 1, 0, 0, 0);
    drive("R2", 16'hFFFF, 16'hFFFF, 1, 1, 0, 2'b10, 0, 0, 0, 0, 0);
    drive("R2", 16'hFFFF, 16'hFFFF, 1, 0, 0, 2'b10, 0, 0, 0, 0, 0);
    // R4 / R5: fractional mode and its corner
    drive("R4", 16'h4000, 16'h4000, 1, 1, 1, 2'b10, 0, 0, 0, 0, 0);
    drive("R4", 16'h8000, 16'h8000, 0, 0, 1, 2'b10, 0, 1, 0, 0, 0);
    drive("R5", 16'h8000, 16'h8000, 1, 1, 1, 2'b10, 0, 0, 0, 0, 0);
    drive("R5", 16'h8000, 16'h8000, 1, 1, 0, 2'b10, 0, 1, 0, 0, 0);
    // R6: rounding at and below the half point
    drive("R6", 16'h0001, 16'h8000, 0, 0, 0, 2'b10, 0, 1, 1, 0, 0);
    drive("R6", 16'h0001, 16'h7FFF, 0, 0, 0, 2'b10, 0, 1, 1, 0, 0);
    drive("R6", 16'h1234, 16'h5678, 1, 1, 0, 2'b00, 1, 1, 1, 0, 0);
    // R7: overflow and saturation both ways
    drive("R7", 16'h8000, 16'h8000, 1, 1, 1, 2'b10, 0, 0, 0, 0, 0);
    drive("R7", 16'h4000, 16'h4000, 1, 1, 0, 2'b00, 0, 1, 0, 1, 0);
    drive("R7", 16'h4000, 16'h4000, 1, 1, 0, 2'b00, 0, 0, 0, 0, 0);
    drive("R7", 16'h8000, 16'h7FFF, 1, 1, 0, 2'b10, 0, 1, 0, 0, 0);
    drive("R7", 16'h7FFF, 16'h7FFF, 1, 1, 0, 2'b01, 1, 1, 0, 1, 0);
    drive("R7", 16'h7FFF, 16'h7FFF, 1, 1, 1, 2'b01, 1, 1, 0, 1, 0);
    // R8: zero flag
    drive("R8", 16'd0, 16'd5, 1, 1, 0, 2'b10, 0, 0, 0, 0, 0);
    drive("R8", 16'd3, 16'd5, 1, 1, 0, 2'b10, 0, 1, 0, 0, 0);
    drive("R8", 16'd3, 16'd5, 1, 1, 0, 2'b01, 1, 1, 0, 0, 0);
    // R9: T register as Y source
    load_t(16'h0009);
    drive("R9", 16'd4, 16'h1234, 1, 1, 0, 2'b10, 0, 0, 0, 0, 1);
    load_t(16'hFFFE);
    drive("R9", 16'd3, 16'h0001, 1, 1, 0, 2'b00, 0, 0, 0, 0, 1);

    // R10: idle cycles with noisy controls leave state alone
    x_data = 16'h7777; y_data = 16'h5555; mac_op = 2'b00; sat_en = 1; rnd_en = 1; dst_sel = 1;
    repeat (3) @(negedge clk);
    chk("R10", "acc_a idle", acc_a, m_a);
    chk("R10", "acc_b idle", acc_b, m_b);
    chk("R10", "flags idle", {38'b0, zero_flag, ovf_flag}, {38'b0, m_z, m_o});

    repeat (2) @(negedge clk);
    chk("R10", "scoreboard drained", 40'(sb.size()), 40'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule